// File: doc/BRIEF.md
# Byte-Flip Parity Line Framer

This block turns each 16-bit scrambled word and its data/control flag into a 20-bit line word, ready for the line modulator. It counts the ones in each byte. A byte with fewer than half of its bits set is sent inverted, and a flip bit beside it records that. Each byte carries one marker bit. The two markers name the word class, and both are inverted when the word's parity is odd. Every transmitted byte therefore carries at least four ones, which bounds zero runs on the line to 10 bits. The cost is four extra bits per 16, an overhead of 25%.

The transmit side also keeps a saturating tally of the excess ones it has sent. It raises a correction request once the tally passes a set limit, so that the link layer can insert a balancing word. The receive side undoes the flips, recomputes the parity, removes it from the markers and recovers the class. It flags marker pairs that decode to no valid class. Each direction is one registered stage with valid/ready handshakes on both sides.

Top module: `flip_line_framer`

## Requirements
- R1: Line layout from the LSB: byte0 in [7:0], flip0 at bit 8, marker0 at bit 9, byte1 in [17:10], flip1 at bit 18, marker1 at bit 19. A source byte with fewer than 4 ones is placed inverted and its flip bit is 1. Otherwise it is placed unchanged and its flip bit is 0.
- R2: The base marker pair {marker1, marker0} is 01 for data and 10 for control. It is inverted in both bits when p = XOR of the 16 source bits XOR flip0 XOR flip1 is 1.
- R3: Every byte field of a valid line word holds at least 4 ones. No run of zeros longer than 10 bits occurs in the transmitted bit stream, read LSB first, word after word.
- R4: Each direction has one cycle of latency. While reset is held, and right after it, both output valids are low, the disparity level is 0 and the correction request is low.
- R5: When a transmit output word is valid and not accepted, it stays valid and unchanged and tx_in_ready is low. The disparity level does not change.
- R6: Each accepted transmit word adds (ones-4) of each transmitted byte, taken after flipping, to a signed 8-bit disparity level. The level saturates at 127 and does not wrap.
- R7: corr_req is high exactly when the disparity level is above DISP_LIMIT (default 64).
- R8: The receive side inverts each byte whose flip bit is set and recomputes p over the restored bytes and the flip bits. It removes p from the markers and outputs the 16-bit word with rx_out_ctrl=1 when the pair then reads 10.
- R9: rx_err is high, together with the word, when the parity-removed marker pair reads 00 or 11. It is never high while rx_out_valid is low.
- R10: When a receive output word is valid and not accepted, it stays valid and unchanged and rx_in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in_valid | input | 1 | Transmit word offered |
| tx_in_ready | output | 1 | Transmit word taken this cycle |
| tx_in_data | input | 16 | Scrambled payload word |
| tx_in_ctrl | input | 1 | 1 = control word, 0 = data word |
| tx_out_valid | output | 1 | Line word present |
| tx_out_ready | input | 1 | Modulator takes the line word |
| tx_line | output | 20 | Encoded line word |
| disp_level | output | 8 | Signed saturating disparity level |
| corr_req | output | 1 | Balancing word requested |
| rx_in_valid | input | 1 | Received line word offered |
| rx_in_ready | output | 1 | Received line word taken |
| rx_in_line | input | 20 | Received line word |
| rx_out_valid | output | 1 | Restored word present |
| rx_out_ready | input | 1 | Consumer takes the restored word |
| rx_out_data | output | 16 | Restored payload |
| rx_out_ctrl | output | 1 | Restored class, 1 = control |
| rx_err | output | 1 | Marker pair failed the parity check |

## Verification
Assertions check on every cycle that each valid line word has at least four ones per byte field and two markers that differ. They also check that stalled words on either side hold still, that the disparity level never falls and moves only when a word is accepted, and that rx_err never appears without a valid word. The bench alone shows the exact encoding, because it sweeps all 65536 payloads through both directions against an arithmetic model. Only the bench shows the zero-run bound across word boundaries, the saturation point, the correction threshold and detection of single marker upsets.

// File: rtl/framer_pkg.sv
package framer_pkg;
  // Marker pair {marker1, marker0} before the parity flag is folded in.
  typedef enum logic [1:0] {
    MK_DATA = 2'b01,
    MK_CTRL = 2'b10
  } mark_t;

  function automatic logic [1:0] base_marks(input logic is_ctrl);
    return is_ctrl ? MK_CTRL : MK_DATA;
  endfunction
endpackage

// File: rtl/fr_lane_enc.sv
module fr_lane_enc #(
  parameter int BYTE_W = 8,
  localparam int CW = $clog2(BYTE_W + 1)
) (
  input  logic [BYTE_W-1:0] raw,
  output logic [BYTE_W-1:0] coded,
  output logic              flip,
  output logic [CW-1:0]     ones_out
);
  localparam logic [CW-1:0] HALF = CW'(BYTE_W / 2);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < BYTE_W; i++) ones = ones + CW'(raw[i]);
  end

  always_comb begin
    flip     = (ones < HALF);
    coded    = flip ? ~raw : raw;
    ones_out = flip ? (FULL - ones) : ones;
  end
endmodule

// File: rtl/fr_disparity.sv
module fr_disparity #(
  parameter int BYTE_W     = 8,
  parameter int DISP_W     = 8,
  parameter int DISP_LIMIT = 64,
  localparam int EW = $clog2(BYTE_W + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [EW-1:0]     excess,
  output logic [DISP_W-1:0] level,
  output logic              corr_req
);
  localparam logic signed [DISP_W:0]   TOP = (DISP_W+1)'((2 ** (DISP_W - 1)) - 1);
  localparam logic signed [DISP_W-1:0] LIM = DISP_W'(DISP_LIMIT);

  logic signed [DISP_W:0] wide;
  logic [DISP_W-1:0]      lvl_d, lvl_q;

  always_comb begin
    wide  = $signed({lvl_q[DISP_W-1], lvl_q}) + $signed((DISP_W+1)'(excess));
    lvl_d = (wide > TOP) ? TOP[DISP_W-1:0] : wide[DISP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lvl_q <= '0;
    else if (fire) lvl_q <= lvl_d;
  end

  assign level    = lvl_q;
  assign corr_req = ($signed(lvl_q) > LIM);

  // R6
  level_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ($signed(level) >= $signed($past(level))));
  // R5
  level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(level));
endmodule

// File: rtl/fr_tx.sv
module fr_tx #(
  parameter int BYTE_W = 8,
  localparam int CW = $clog2(BYTE_W + 1),
  localparam int EW = CW + 1,
  localparam int LS = BYTE_W + 2,
  localparam int LINE_W = 2 * LS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2*BYTE_W-1:0] in_data,
  input  logic                in_ctrl,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LINE_W-1:0]   out_line,
  output logic                fire,
  output logic [EW-1:0]       excess
);
  import framer_pkg::*;

  localparam logic [EW-1:0] HALF = EW'(BYTE_W / 2);

  logic [1:0][BYTE_W-1:0] coded;
  logic [1:0]             fl;
  logic [1:0][CW-1:0]     ones;
  logic                   par;
  logic [1:0]             mk;
  logic [LINE_W-1:0]      line_d, line_q;
  logic                   vld_d, vld_q;

  for (genvar k = 0; k < 2; k++) begin : g_lane
    fr_lane_enc #(.BYTE_W(BYTE_W)) u_enc (
      .raw      (in_data[k*BYTE_W +: BYTE_W]),
      .coded    (coded[k]),
      .flip     (fl[k]),
      .ones_out (ones[k])
    );
  end

  always_comb begin
    par    = (^in_data) ^ fl[0] ^ fl[1];
    mk     = base_marks(in_ctrl) ^ {par, par};
    line_d = {mk[1], fl[1], coded[1], mk[0], fl[0], coded[0]};
    excess = (EW'(ones[0]) - HALF) + (EW'(ones[1]) - HALF);
  end

  always_comb begin
    in_ready = !vld_q || out_ready;
    fire     = in_valid && in_ready;
    if (fire)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    else                vld_d = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    line_q <= '0;
    else if (fire) line_q <= line_d;
  end

  assign out_valid = vld_q;
  assign out_line  = line_q;

  // R3
  min_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (($countones(out_line[BYTE_W-1:0]) >= BYTE_W/2) &&
                   ($countones(out_line[LS +: BYTE_W]) >= BYTE_W/2)));
  // R2
  marker_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_line[BYTE_W+1] != out_line[LINE_W-1]));
  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_line)));
endmodule

// File: rtl/fr_rx.sv
module fr_rx #(
  parameter int BYTE_W = 8,
  localparam int LS = BYTE_W + 2,
  localparam int LINE_W = 2 * LS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LINE_W-1:0]   in_line,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*BYTE_W-1:0] out_data,
  output logic                out_ctrl,
  output logic                out_err
);
  import framer_pkg::*;

  logic [1:0][BYTE_W-1:0] rest;
  logic [1:0]             fl, mk;
  logic                   par, take;
  logic [1:0]             unmk;
  logic                   ctrl_d, err_d;
  logic                   vld_d, vld_q, ctrl_q, err_q, errn_d;
  logic [2*BYTE_W-1:0]    data_q;

  for (genvar k = 0; k < 2; k++) begin : g_lane
    assign fl[k]   = in_line[k*LS + BYTE_W];
    assign mk[k]   = in_line[k*LS + BYTE_W + 1];
    assign rest[k] = fl[k] ? ~in_line[k*LS +: BYTE_W] : in_line[k*LS +: BYTE_W];
  end

  always_comb begin
    par    = (^rest) ^ fl[0] ^ fl[1];
    unmk   = mk ^ {par, par};
    ctrl_d = (unmk == MK_CTRL);
    err_d  = (unmk[0] == unmk[1]);
  end

  always_comb begin
    in_ready = !vld_q || out_ready;
    take     = in_valid && in_ready;
    if (take)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    else                vld_d = vld_q;
    if (take)           errn_d = err_d;
    else if (out_ready) errn_d = 1'b0;
    else                errn_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      err_q <= errn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= 1'b0;
    end else if (take) begin
      data_q <= rest;
      ctrl_q <= ctrl_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_ctrl  = ctrl_q;
  assign out_err   = err_q;

  // R9
  err_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);
  // R10
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_ctrl) && $stable(out_err)));
endmodule

// File: rtl/flip_line_framer.sv
module flip_line_framer #(
  parameter int BYTE_W     = 8,
  parameter int DISP_W     = 8,
  parameter int DISP_LIMIT = 64,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int LINE_W = WORD_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [WORD_W-1:0] tx_in_data,
  input  logic              tx_in_ctrl,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [LINE_W-1:0] tx_line,
  output logic [DISP_W-1:0] disp_level,
  output logic              corr_req,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [LINE_W-1:0] rx_in_line,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [WORD_W-1:0] rx_out_data,
  output logic              rx_out_ctrl,
  output logic              rx_err
);
  localparam int EW = $clog2(BYTE_W + 1) + 1;

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic          tx_fire;
  logic [EW-1:0] tx_excess;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  fr_tx #(.BYTE_W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   (tx_in_data),
    .in_ctrl   (tx_in_ctrl),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_line  (tx_line),
    .fire      (tx_fire),
    .excess    (tx_excess)
  );

  fr_disparity #(.BYTE_W(BYTE_W), .DISP_W(DISP_W), .DISP_LIMIT(DISP_LIMIT)) u_disp (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fire     (tx_fire),
    .excess   (tx_excess),
    .level    (disp_level),
    .corr_req (corr_req)
  );

  fr_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_line   (rx_in_line),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_out_data),
    .out_ctrl  (rx_out_ctrl),
    .out_err   (rx_err)
  );
endmodule

// File: tb/sim_flip_line_framer.sv
module sim_flip_line_framer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_in_valid, tx_in_ready, tx_in_ctrl;
  logic [15:0] tx_in_data;
  logic        tx_out_valid, tx_out_ready;
  logic [19:0] tx_line;
  logic [7:0]  disp_level;
  logic        corr_req;
  logic        rx_in_valid, rx_in_ready;
  logic [19:0] rx_in_line;
  logic        rx_out_valid, rx_out_ready;
  logic [15:0] rx_out_data;
  logic        rx_out_ctrl, rx_err;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  int md;
  int run, max_run;

  always #5 clk = ~clk;

  flip_line_framer u0 (
    .clk(clk), .rst_n(rst_n),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
    .tx_in_data(tx_in_data), .tx_in_ctrl(tx_in_ctrl),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .tx_line(tx_line), .disp_level(disp_level), .corr_req(corr_req),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_line(rx_in_line),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
    .rx_out_data(rx_out_data), .rx_out_ctrl(rx_out_ctrl), .rx_err(rx_err)
  );

  function automatic logic [19:0] enc(input logic [15:0] d, input logic c);
    logic f0, f1, p;
    logic [1:0] mk;
    f0 = ($countones(d[7:0]) < 4);
    f1 = ($countones(d[15:8]) < 4);
    p  = (^d) ^ f0 ^ f1;
    mk = (c ? 2'b10 : 2'b01) ^ {p, p};
    return {mk[1], f1, (f1 ? ~d[15:8] : d[15:8]), mk[0], f0, (f0 ? ~d[7:0] : d[7:0])};
  endfunction

  function automatic int excess_of(input logic [15:0] d);
    int a, b;
    a = $countones(d[7:0]);
    b = $countones(d[15:8]);
    if (a < 4) a = 8 - a;
    if (b < 4) b = 8 - b;
    return (a - 4) + (b - 4);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tx_in_valid = 1'b0; rx_in_valid = 1'b0;
    tx_out_ready = 1'b1; rx_out_ready = 1'b1;
    tx_in_data = '0; tx_in_ctrl = 1'b0; rx_in_line = '0;
    repeat (3) @(negedge clk);
    chk(tx_out_valid, 0, "R4 tx valid in reset");
    chk(rx_out_valid, 0, "R4 rx valid in reset");
    chk(disp_level, 0, "R4 disparity in reset");
    chk(corr_req, 0, "R4 corr_req in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx_out_valid, 0, "R4 tx valid after reset");
    md = 0;
  endtask

  task automatic track_run(input logic [19:0] w);
    for (int b = 0; b < 20; b++) begin
      if (w[b]) run = 0;
      else begin
        run++;
        if (run > max_run) max_run = run;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R6 R7: saturation and threshold with all-zero words (+8 each)
    tx_in_valid = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      tx_in_data = 16'h0000; tx_in_ctrl = 1'b0;
      @(negedge clk);
      md = md + 8; if (md > 127) md = 127;
      chk(tx_line, enc(16'h0000, 1'b0), "R1 zero word line");
      chk(disp_level, md[7:0], "R6 saturating level");
      chk(corr_req, (md > 64), "R7 correction threshold");
    end
    tx_in_valid = 1'b0;
    @(negedge clk);

    // Full sweep through both directions
    do_reset();
    run = 0; max_run = 0;
    tx_in_valid = 1'b1; rx_in_valid = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] d;
      logic c;
      d = i[15:0];
      c = (i % 3 == 0);
      tx_in_data = d; tx_in_ctrl = c; rx_in_line = enc(d, c);
      @(negedge clk);
      md = md + excess_of(d); if (md > 127) md = 127;
      chk(tx_out_valid, 1, "R4 tx one-cycle latency");
      chk(tx_line, enc(d, c), "R1 R2 line encoding");
      chk(disp_level, md[7:0], "R6 level in sweep");
      chk(corr_req, (md > 64), "R7 corr_req in sweep");
      chk(rx_out_valid, 1, "R4 rx one-cycle latency");
      chk(rx_out_data, d, "R8 restored data");
      chk(rx_out_ctrl, c, "R8 restored class");
      chk(rx_err, 0, "R9 no error on clean word");
      track_run(tx_line);
    end
    chk(max_run <= 10, 1, "R3 zero run at most 10");
    chk(max_run, 10, "R3 longest zero run reached");

    // R9: single marker upsets
    tx_in_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      logic [15:0] d;
      d = 16'(k * 16'h1111 + 3);
      rx_in_line = enc(d, k[0]) ^ ((k < 4) ? 20'h00200 : 20'h80000);
      @(negedge clk);
      chk(rx_out_valid, 1, "R9 upset word valid");
      chk(rx_err, 1, "R9 marker upset flagged");
    end
    rx_in_valid = 1'b0;
    @(negedge clk);
    chk(rx_out_valid, 0, "R9 idle valid");
    chk(rx_err, 0, "R9 error cleared when idle");

    // R5 R10: backpressure
    do_reset();
    tx_out_ready = 1'b0; rx_out_ready = 1'b0;
    tx_in_valid = 1'b1; rx_in_valid = 1'b1;
    tx_in_data = 16'h0000; tx_in_ctrl = 1'b1; rx_in_line = enc(16'hA5C3, 1'b1);
    @(negedge clk);
    chk(tx_line, enc(16'h0000, 1'b1), "R5 first word");
    chk(disp_level, 8, "R6 level after first word");
    tx_in_data = 16'h00FF; tx_in_ctrl = 1'b0; rx_in_line = enc(16'h1234, 1'b0);
    @(negedge clk);
    chk(tx_in_ready, 0, "R5 tx in_ready low while stalled");
    chk(tx_out_valid, 1, "R5 stalled word valid");
    chk(tx_line, enc(16'h0000, 1'b1), "R5 stalled word held");
    chk(disp_level, 8, "R5 level held while stalled");
    chk(rx_in_ready, 0, "R10 rx in_ready low while stalled");
    chk(rx_out_data, 16'hA5C3, "R10 stalled rx data held");
    chk(rx_out_ctrl, 1, "R10 stalled rx class held");
    tx_out_ready = 1'b1; rx_out_ready = 1'b1;
    @(negedge clk);
    chk(tx_line, enc(16'h00FF, 1'b0), "R5 next word after release");
    chk(disp_level, 16, "R6 level after release");
    chk(rx_out_data, 16'h1234, "R10 next rx word after release");
    tx_in_valid = 1'b0; rx_in_valid = 1'b0;
    @(negedge clk);
    chk(tx_out_valid, 0, "R4 tx drains");
    chk(rx_out_valid, 0, "R4 rx drains");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule